// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block is one timer of a processor's timer set: a free-running count that advances by one on every clock, paired with a compare limit that raises an interrupt request. Software may load the count at any time. The top bit of every count word is not part of the count: it is a separate trap flag, and the count wraps modulo 2^63 without disturbing it. Reads return the running count with that flag in bit 63.

Software arms the compare by writing a limit word. Bit 63 of that word is an interrupt-disable flag, and the low 63 bits are the compare value. A value of zero, or a set disable bit, cancels any armed compare. A value that the count has already reached fires on the next tick. Otherwise the block fires when the count reaches the value. Each arming yields exactly one single-cycle pulse. The pulse goes to the tick softint line or the system-tick softint line, chosen by a parameter. One instance serves the tick timer, and instances of the system or hypervisor kind serve the other two timers.

Top module: `tick_timer`

## Requirements
- R1: While reset is applied, the read word is 64'h8000_0000_0000_0000, meaning the trap flag is 1 and the count is 0. After reset no pulse appears until a limit is written.
- R2: When not written, the count advances by exactly one per clock cycle.
- R3: A count write loads bits 62:0 of the written word. The read word shows that value in the cycle after the write, and counting continues from it.
- R4: Bit 63 of a count write is stored as the trap flag. Bit 63 of every read equals the last written flag: 1 forces bit 63 high, and 0 reads as 0.
- R5: The count wraps from 2^63-1 to 0, and the trap flag in bit 63 is unchanged.
- R6: Suppose a limit word has bit 63 clear and a nonzero value L, and L is greater than the count C sampled in its write cycle. Then exactly one one-cycle pulse appears, in the cycle whose read count (bits 62:0) equals L+1.
- R7: After it fires, the compare stays disarmed until the limit is written again. Reloading the count so that it passes L again gives no pulse.
- R8: A limit word with bit 63 set produces no pulse and cancels a previously armed compare.
- R9: A limit word whose bits 62:0 are zero produces no pulse and cancels a previously armed compare.
- R10: An enabled nonzero limit value L with L <= C fires one pulse, in the cycle whose read count equals C+2 modulo 2^63.
- R11: With KIND set to the tick kind, pulses appear on `set_tick_irq` and `set_stick_irq` stays 0. With the system kind, the same pulses appear on `set_stick_irq` and `set_tick_irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count advances on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnt_wr_en | input | 1 | Load the count and trap flag from `cnt_wr_data` |
| cnt_wr_data | input | 64 | Bit 63 is the trap flag; bits 62:0 are the new count |
| cnt_rd_data | output | 64 | Running count with the trap flag in bit 63 |
| lim_wr_en | input | 1 | Write the limit from `lim_wr_data` |
| lim_wr_data | input | 64 | Bit 63 is the interrupt disable; bits 62:0 are the compare value |
| set_tick_irq | output | 1 | One-cycle request to set the tick softint bit |
| set_stick_irq | output | 1 | One-cycle request to set the system-tick softint bit |

## Verification
A table of count and limit pairs exercises the compare. The pairs place the limit ahead of the count, equal to it, and behind it. They also include a limit set just before the wrap point, a late limit whose firing count lands across the wrap, a disabled limit and a zero limit. Together these tell the equality path (pulse at L+1) apart from the late path (pulse at C+2), and both apart from the cancelling cases that must stay silent. Directed sequences reload the count after a firing to show the compare does not re-arm, and cancel an armed compare midway by a disable and by a zero. A second instance of the system kind, driven in parallel, shows that pulses are routed only to the line that KIND selects.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int unsigned WORD_W_DEF = 64;

    typedef enum logic [1:0] {
        KIND_TICK = 2'd0,
        KIND_SYS  = 2'd1,
        KIND_HYP  = 2'd2
    } timer_kind_e;

    // compare state held between limit writes
    typedef struct packed {
        logic armed;   // a compare is pending
        logic late;    // value was at or behind the count when written
        logic dis;     // interrupt-disable flag from the last limit write
    } cmp_flags_t;

    localparam cmp_flags_t CMP_FLAGS_RESET = '{armed: 1'b0, late: 1'b0, dis: 1'b1};

    function automatic logic kind_uses_tick_line(input timer_kind_e k);
        return k == KIND_TICK;
    endfunction

endpackage

// File: rtl/tick_count.sv
module tick_count #(
    parameter int unsigned VAL_W = 63
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [VAL_W:0]   wr_word,
    output logic [VAL_W-1:0] cnt,
    output logic             trap_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            trap_flag <= 1'b1;
        end else if (wr_en) begin
            cnt       <= wr_word[VAL_W-1:0];
            trap_flag <= wr_word[VAL_W];
        end else begin
            cnt       <= cnt + 1'b1;
        end
    end

    // R2 R5
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |-> (cnt == $past(cnt) + 1'b1));

    // R4
    trap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |-> $stable(trap_flag));

endmodule

// File: rtl/tick_compare.sv
module tick_compare
    import tick_timer_pkg::*;
#(
    parameter int unsigned VAL_W = 63
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [VAL_W:0]   wr_word,
    input  logic [VAL_W-1:0] cnt,
    output logic             fire
);

    logic [VAL_W-1:0] lim_val;
    cmp_flags_t       flags;
    logic             fire_q;
    logic             hit;
    logic [VAL_W-1:0] new_val;
    logic             new_dis;

    assign new_val = wr_word[VAL_W-1:0];
    assign new_dis = wr_word[VAL_W];

    // equality each cycle; the magnitude test is done once, at the write
    assign hit = flags.armed && (flags.late || (cnt == lim_val));

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_val <= '0;
            flags   <= CMP_FLAGS_RESET;
            fire_q  <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (wr_en) begin
                lim_val     <= new_val;
                flags.dis   <= new_dis;
                flags.armed <= (|new_val) && !new_dis;
                flags.late  <= (new_val <= cnt);
            end else if (hit) begin
                fire_q      <= 1'b1;
                flags.armed <= 1'b0;
                flags.late  <= 1'b0;
            end
        end
    end

    assign fire = fire_q;

    // R6
    fire_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        fire_q |-> $past(flags.armed));

    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        fire_q |=> !fire_q);

    // R7
    fire_once_chk: assert property (@(posedge clk) disable iff (rst)
        fire_q |-> !flags.armed);

    // R8
    dis_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        flags.dis |-> !flags.armed);

    // R9
    zero_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        flags.armed |-> (lim_val != '0));

    // R10
    late_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.armed && flags.late && !wr_en) |=> fire_q);

endmodule

// File: rtl/tick_route.sv
module tick_route
    import tick_timer_pkg::*;
#(
    parameter timer_kind_e KIND = KIND_TICK
) (
    input  logic fire,
    output logic set_tick,
    output logic set_stick
);

    generate
        if (kind_uses_tick_line(KIND)) begin : g_tick_line
            assign set_tick  = fire;
            assign set_stick = 1'b0;
        end else begin : g_stick_line
            assign set_tick  = 1'b0;
            assign set_stick = fire;
        end
    endgenerate

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter timer_kind_e KIND   = KIND_TICK,
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_wr_en,
    input  logic [WORD_W-1:0] cnt_wr_data,
    output logic [WORD_W-1:0] cnt_rd_data,
    input  logic              lim_wr_en,
    input  logic [WORD_W-1:0] lim_wr_data,
    output logic              set_tick_irq,
    output logic              set_stick_irq
);

    localparam int unsigned VAL_W = WORD_W - 1;

    logic [VAL_W-1:0] cnt;
    logic             trap_flag;
    logic             fire;

    tick_count #(.VAL_W(VAL_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cnt_wr_en),
        .wr_word   (cnt_wr_data),
        .cnt       (cnt),
        .trap_flag (trap_flag)
    );

    tick_compare #(.VAL_W(VAL_W)) u_compare (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (lim_wr_en),
        .wr_word (lim_wr_data),
        .cnt     (cnt),
        .fire    (fire)
    );

    tick_route #(.KIND(KIND)) u_route (
        .fire      (fire),
        .set_tick  (set_tick_irq),
        .set_stick (set_stick_irq)
    );

    assign cnt_rd_data = {trap_flag, cnt};

    // R11
    route_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({set_tick_irq, set_stick_irq}));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !(set_tick_irq || set_stick_irq));

endmodule

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
    import tick_timer_pkg::*;

    localparam logic [63:0] TOP = 64'h8000_0000_0000_0000;
    localparam logic [62:0] M63 = '1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_wr_en = 1'b0;
    logic [63:0] cnt_wr_data = '0;
    logic        lim_wr_en = 1'b0;
    logic [63:0] lim_wr_data = '0;
    logic [63:0] rd, rd_s;
    logic        t0, s0, t1, s1;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    tick_timer #(.KIND(KIND_TICK)) dut (
        .clk(clk), .rst(rst), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .cnt_rd_data(rd), .lim_wr_en(lim_wr_en), .lim_wr_data(lim_wr_data),
        .set_tick_irq(t0), .set_stick_irq(s0));

    tick_timer #(.KIND(KIND_SYS)) dut_sys (
        .clk(clk), .rst(rst), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .cnt_rd_data(rd_s), .lim_wr_en(lim_wr_en), .lim_wr_data(lim_wr_data),
        .set_tick_irq(t1), .set_stick_irq(s1));

    typedef struct packed {
        logic [63:0] start;
        logic [63:0] limw;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{64'd100, 64'd110},
        '{64'd100, 64'd100},
        '{64'd100, 64'd50},
        '{TOP | 64'd100, TOP | 64'd110},
        '{64'd100, 64'd0},
        '{64'h7FFF_FFFF_FFFF_FFF0, 64'd5},
        '{64'h7FFF_FFFF_FFFF_FFF0, 64'h7FFF_FFFF_FFFF_FFFA},
        '{64'd0, 64'd1},
        '{64'h7FFF_FFFF_FFFF_FFFE, 64'd3}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_cnt(input logic [63:0] v);
        cnt_wr_en = 1'b1; cnt_wr_data = v;
        @(negedge clk);
        cnt_wr_en = 1'b0;
    endtask

    task automatic wr_lim(input logic [63:0] v);
        lim_wr_en = 1'b1; lim_wr_data = v;
        @(negedge clk);
        lim_wr_en = 1'b0;
    endtask

    // watch n cycles, count tick pulses, check routing (R11) each cycle
    task automatic watch(input int n, output int pulses, output logic [63:0] at_rd);
        pulses = 0; at_rd = '0;
        for (int i = 0; i < n; i++) begin
            if (t0) begin pulses++; at_rd = rd; end
            chk(!s0 && !t1 && (s1 == t0), "R11 routing", {60'd0, t0, s0, t1, s1}, {60'd0, t0, 1'b0, 1'b0, t0});
            @(negedge clk);
        end
    endtask

    task automatic run_vectors();
        for (int i = 0; i < 9; i++) begin
            automatic vec_t v = VECS[i];
            automatic logic [62:0] s = v.start[62:0];
            automatic logic [62:0] l = v.limw[62:0];
            automatic bit en = !v.limw[63] && (l != '0);
            automatic logic [62:0] exp_at = (l > s) ? (l + 63'd1) : ((s + 63'd2) & M63);
            int p;
            logic [63:0] at;
            wr_cnt(v.start);
            wr_lim(v.limw);
            watch(40, p, at);
            if (en) begin
                // R6 (ahead) / R10 (late)
                chk(p == 1, (l > s) ? "R6 pulse count" : "R10 pulse count", 64'(p), 64'd1);
                chk(at == {v.start[63], exp_at}, (l > s) ? "R6 pulse time" : "R10 pulse time", at, {v.start[63], exp_at});
            end else begin
                chk(p == 0, v.limw[63] ? "R8 disabled limit" : "R9 zero limit", 64'(p), 64'd0);
            end
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int p;
        logic [63:0] at, r;
        step(3);
        // R1 reset state
        chk(rd == TOP, "R1 reset read", rd, TOP);
        chk(!t0 && !s1, "R1 no pulse in reset", {62'd0, t0, s1}, 64'd0);
        rst = 1'b0;
        step(1);
        // R2 counting
        chk(rd == (TOP | 64'd1), "R2 first count", rd, TOP | 64'd1);
        r = rd; step(1);
        chk(rd == r + 64'd1, "R2 increment", rd, r + 64'd1);
        watch(20, p, at);
        chk(p == 0, "R1 disabled after reset", 64'(p), 64'd0);

        // R3 / R4 count load and trap flag
        wr_cnt(TOP | 64'd5);
        chk(rd == (TOP | 64'd5), "R3 load", rd, TOP | 64'd5);
        step(1);
        chk(rd == (TOP | 64'd6), "R3 continue", rd, TOP | 64'd6);
        wr_cnt(64'd9);
        chk(rd == 64'd9, "R4 flag cleared", rd, 64'd9);

        // R5 wrap
        wr_cnt(64'hFFFF_FFFF_FFFF_FFFE);
        step(1);
        chk(rd == 64'hFFFF_FFFF_FFFF_FFFF, "R5 before wrap", rd, 64'hFFFF_FFFF_FFFF_FFFF);
        step(1);
        chk(rd == TOP, "R5 wrap keeps flag", rd, TOP);
        wr_cnt(64'h7FFF_FFFF_FFFF_FFFF);
        step(1);
        chk(rd == 64'd0, "R5 wrap flag clear", rd, 64'd0);

        // R6 R8 R9 R10 R11 table
        run_vectors();

        // R7 no re-arm
        wr_cnt(64'd0);
        wr_lim(64'd10);
        watch(20, p, at);
        chk(p == 1, "R7 first fire", 64'(p), 64'd1);
        wr_cnt(64'd0);
        watch(30, p, at);
        chk(p == 0, "R7 no re-arm", 64'(p), 64'd0);

        // R8 cancel by disable
        wr_cnt(64'd0);
        wr_lim(64'd20);
        step(5);
        wr_lim(TOP | 64'd20);
        watch(40, p, at);
        chk(p == 0, "R8 cancel", 64'(p), 64'd0);

        // R9 cancel by zero
        wr_cnt(64'd0);
        wr_lim(64'd20);
        step(5);
        wr_lim(64'd0);
        watch(40, p, at);
        chk(p == 0, "R9 cancel", 64'(p), 64'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule